// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Unit

This unit moves a 16-bit or 32-bit register value to or from an 8-bit peripheral whose registers occupy every second byte address. A start strobe samples a base address, a 16-bit displacement, the direction, the size and the current register value. The unit then issues one byte access per cycle group on a byte-wide request/acknowledge port. It begins with the most significant byte that takes part, and each later address is two above the one before.

On a write, the register bytes are scattered onto the bus. On a read, the returned bytes are gathered into a result word. A one-cycle done pulse marks the end of the transfer. Arbitration, alignment faults and instruction decoding belong to the surrounding logic.

Top module: `apx_xfer_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req_o`, `done_o` and `busy_o` are 0 and `reg_rdata_o` is 0.
- R2: The first byte address is `base_i` plus `disp_i` sign-extended to 32 bits, taken modulo 2^32.
- R3: With `size_long_i`=1 and `dir_rd_i`=0 (write, `mem_we_o`=1), four accesses carry register bits 31–24, 23–16, 15–8 and 7–0 to addresses EA, EA+2, EA+4 and EA+6, in that order. `reg_rdata_o` then holds the register value sampled at start.
- R4: With `size_long_i`=1 and `dir_rd_i`=1 (read, `mem_we_o`=0), four accesses at EA, EA+2, EA+4 and EA+6 fill result bits 31–24, 23–16, 15–8 and 7–0 respectively.
- R5: With `size_long_i`=0 and a write, exactly two accesses occur: bits 15–8 go to EA, then bits 7–0 go to EA+2.
- R6: With `size_long_i`=0 and a read, exactly two accesses occur: EA fills bits 15–8 and EA+2 fills bits 7–0. Result bits 31–16 equal `reg_wdata_i` as sampled at start.
- R7: Only one access is outstanding at a time. Request, address, write enable and write data stay unchanged until acknowledge is sampled high. The next address is the previous one plus 2, wrapping modulo 2^32.
- R8: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is a single-cycle pulse in the cycle after the final acknowledge.
- R9: A start strobe while `busy_o` is high, including the done cycle itself, has no effect on the transfer sequence and does not begin a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (accepted only while idle) |
| dir_rd_i | input | 1 | 1 = peripheral to register, 0 = register to peripheral |
| size_long_i | input | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| base_i | input | 32 | Base address |
| disp_i | input | 16 | Signed displacement |
| reg_wdata_i | input | 32 | Register value sampled at start |
| reg_rdata_o | output | 32 | Gathered result (or held source on write) |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte |
| mem_ack_i | input | 1 | Access complete this cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (one cycle) |

## Verification
Two events can land in the same cycle. A fresh start strobe can coincide with the done pulse, and another strobe can arrive while an access is still waiting for acknowledge. The bench raises start in exactly the cycle where `done_o` is observed high, and again in the middle of a transfer with a different base. It then checks that no request appears afterwards, that `busy_o` falls, and that the logged address and data sequence of the running transfer matches the expected one access for access.

// File: rtl/apx_pkg.sv
package apx_pkg;
   typedef enum logic [1:0] {
      APX_IDLE = 2'd0,
      APX_MOVE = 2'd1,
      APX_FIN  = 2'd2
   } apx_state_e;
endpackage

// File: rtl/apx_addr_gen.sv
module apx_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int EXT_W = ADDR_W - DISP_W;
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] addr_q;

   generate
      if (DISP_W > ADDR_W || DISP_W < 1) begin : g_bad_disp
         $error("apx_addr_gen: displacement width must be 1..ADDR_W");
      end
      if (STEP < 1) begin : g_bad_step
         $error("apx_addr_gen: step must be positive");
      end
      if (EXT_W > 0) begin : g_sext
         assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_full
         assign disp_ext = disp_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= base_i + disp_ext;
      else if (adv_i)  addr_q <= addr_q + STEP_V;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/apx_seq.sv
module apx_seq
   import apx_pkg::*;
#(
   parameter int NLANES = 4,
   localparam int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              long_i,
   input  logic              ack_i,
   output logic              load_o,
   output logic              adv_o,
   output logic              req_o,
   output logic              done_o,
   output logic              busy_o,
   output logic [LANE_W-1:0] lane_o
);
   localparam logic [LANE_W-1:0] LAST_LANE  = LANE_W'(NLANES - 1);
   localparam logic [LANE_W-1:0] SHORT_LANE = LANE_W'(NLANES / 2);

   apx_state_e        state_q;
   logic [LANE_W-1:0] lane_q;

   generate
      if (NLANES < 2 || (NLANES % 2) != 0) begin : g_bad_lanes
         $error("apx_seq: lane count must be even and at least 2");
      end
   endgenerate

   assign load_o = (state_q == APX_IDLE) && start_i;
   assign req_o  = (state_q == APX_MOVE);
   assign adv_o  = req_o && ack_i;
   assign done_o = (state_q == APX_FIN);
   assign busy_o = (state_q != APX_IDLE);
   assign lane_o = lane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= APX_IDLE;
         lane_q  <= '0;
      end else begin
         unique case (state_q)
            APX_IDLE: if (start_i) begin
               state_q <= APX_MOVE;
               lane_q  <= long_i ? '0 : SHORT_LANE;
            end
            APX_MOVE: if (ack_i) begin
               if (lane_q == LAST_LANE) state_q <= APX_FIN;
               else                     lane_q  <= lane_q + 1'b1;
            end
            APX_FIN:  state_q <= APX_IDLE;
            default:  state_q <= APX_IDLE;
         endcase
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/apx_lane.sv
module apx_lane #(
   parameter int REG_W  = 32,
   parameter int BYTE_W = 8,
   localparam int NLANES = REG_W / BYTE_W,
   localparam int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [REG_W-1:0]  load_val_i,
   input  logic              cap_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [REG_W-1:0]  data_o,
   output logic [BYTE_W-1:0] byte_o
);
   logic [BYTE_W-1:0] slot_q [NLANES];

   generate
      if ((REG_W % BYTE_W) != 0) begin : g_bad_width
         $error("apx_lane: register width must be a multiple of byte width");
      end
      for (genvar g = 0; g < NLANES; g++) begin : g_slot
         // lane index 0 addresses the most significant slot
         localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(NLANES - 1 - g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q[g] <= '0;
            else if (load_i)                     slot_q[g] <= load_val_i[g*BYTE_W +: BYTE_W];
            else if (cap_i && lane_i == MY_LANE) slot_q[g] <= byte_i;
         end
         assign data_o[g*BYTE_W +: BYTE_W] = slot_q[g];
      end
   endgenerate

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < NLANES; i++) begin
         if (lane_i == LANE_W'(NLANES - 1 - i)) byte_o = slot_q[i];
      end
   end
endmodule

// File: rtl/apx_xfer_top.sv
module apx_xfer_top #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int REG_W  = 32,
   parameter int BYTE_W = 8,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_rd_i,
   input  logic              size_long_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BYTE_W-1:0] mem_wdata_o,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   input  logic              mem_ack_i,
   output logic              busy_o,
   output logic              done_o
);
   localparam int NLANES = REG_W / BYTE_W;
   localparam int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1;
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic              load, adv, we_q;
   logic [LANE_W-1:0] lane;

   apx_seq #(.NLANES(NLANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(size_long_i),
      .ack_i(mem_ack_i), .load_o(load), .adv_o(adv), .req_o(mem_req_o),
      .done_o(done_o), .busy_o(busy_o), .lane_o(lane)
   );

   apx_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
      .base_i(base_i), .disp_i(disp_i), .addr_o(mem_addr_o)
   );

   apx_lane #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(reg_wdata_i),
      .cap_i(adv && !we_q), .lane_i(lane), .byte_i(mem_rdata_i),
      .data_o(reg_rdata_o), .byte_o(mem_wdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    we_q <= 1'b0;
      else if (load) we_q <= !dir_rd_i;
   end

   assign mem_we_o = we_q;

   // R7
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_wdata_o) && $stable(mem_we_o)));

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STEP_V));

   // R8
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(mem_req_o && mem_ack_i));

   // R8
   req_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && !mem_req_o));
endmodule

// File: tb/tb_apx_xfer_top.sv
module tb_apx_xfer_top;
   localparam time CLK_PERIOD = 10ns;

   typedef struct packed {
      logic [31:0] base;
      logic [15:0] disp;
      logic        is_long;
      logic        rd;
      logic [31:0] val;
      logic [1:0]  lat;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_1000, 16'h0010, 1'b1, 1'b0, 32'h1122_3344, 2'd0},
      '{32'h0000_2000, 16'hFFFE, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'd2},
      '{32'h0000_3001, 16'h0004, 1'b0, 1'b0, 32'hCAFE_5A5A, 2'd1},
      '{32'h0000_4000, 16'h8000, 1'b0, 1'b1, 32'h1234_5678, 2'd0},
      '{32'hFFFF_FFFC, 16'h0002, 1'b1, 1'b1, 32'h0BAD_F00D, 2'd1},
      '{32'h0000_0000, 16'h7FFE, 1'b1, 1'b0, 32'hA1B2_C3D4, 2'd3}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 1'b0, dir_rd_i = 1'b0, size_long_i = 1'b0;
   logic [31:0] base_i = '0, reg_wdata_i = '0, reg_rdata_o, mem_addr_o;
   logic [15:0] disp_i = '0;
   logic        mem_req_o, mem_we_o, busy_o, done_o;
   logic [7:0]  mem_wdata_o, mem_rdata_i = '0;
   logic        mem_ack_i = 1'b0;

   int errors = 0, checks = 0, cycles = 0;
   int lat_cfg = 0, wcnt = 0, log_n = 0;
   logic [31:0] log_addr [8];
   logic        log_we   [8];
   logic [7:0]  log_data [8];

   apx_xfer_top dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
      .size_long_i(size_long_i), .base_i(base_i), .disp_i(disp_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ack_i(mem_ack_i), .busy_o(busy_o), .done_o(done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] periph(input logic [31:0] a);
      return a[7:0] + 8'h5B;
   endfunction

   // peripheral model: acknowledges after lat_cfg wait cycles, logs each access
   always @(negedge clk) begin
      if (mem_req_o) begin
         if (wcnt >= lat_cfg) begin
            mem_ack_i   = 1'b1;
            mem_rdata_i = periph(mem_addr_o);
            if (log_n < 8) begin
               log_addr[log_n] = mem_addr_o;
               log_we[log_n]   = mem_we_o;
               log_data[log_n] = mem_wdata_o;
            end
            log_n = log_n + 1;
            wcnt  = 0;
         end else begin
            mem_ack_i = 1'b0;
            wcnt      = wcnt + 1;
         end
      end else begin
         mem_ack_i = 1'b0;
         wcnt      = 0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (done_o) begin seen = 1'b1; break; end
      end
   endtask

   task automatic run_vec(input vec_t v, input bit poke);
      logic [31:0] ea, exp_res;
      int n, first;
      bit seen;
      ea    = v.base + {{16{v.disp[15]}}, v.disp};
      n     = v.is_long ? 4 : 2;
      first = v.is_long ? 0 : 2;
      exp_res = v.val;
      @(negedge clk);
      log_n = 0; lat_cfg = int'(v.lat);
      base_i = v.base; disp_i = v.disp; size_long_i = v.is_long;
      dir_rd_i = v.rd; reg_wdata_i = v.val; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 busy after start", {31'd0, busy_o}, 32'd1);
      if (poke) begin
         // R9: second strobe mid-transfer with different operands
         base_i = 32'h5555_0000; disp_i = 16'h0100; dir_rd_i = ~v.rd;
         size_long_i = ~v.is_long; reg_wdata_i = 32'h0; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_done(seen);
      chk("R8 done seen", {31'd0, seen}, 32'd1);
      chk("R8 busy in done cycle", {31'd0, busy_o}, 32'd1);
      chk(v.is_long ? "R3/R4 access count" : "R5/R6 access count", log_n, n);
      for (int k = 0; k < n && k < 8; k++) begin
         int lane = first + k;
         logic [31:0] a = ea + 32'(2 * k);
         chk(k == 0 ? "R2 first address" : "R7 address step", log_addr[k], a);
         chk("R3/R4/R5/R6 direction", {31'd0, log_we[k]}, {31'd0, ~v.rd});
         if (!v.rd)
            chk(v.is_long ? "R3 write byte" : "R5 write byte",
                {24'd0, log_data[k]}, {24'd0, v.val[(3-lane)*8 +: 8]});
         else
            exp_res[(3-lane)*8 +: 8] = periph(a);
      end
      chk(v.rd ? (v.is_long ? "R4 gathered" : "R6 gathered, upper kept") : "R3 source held",
          reg_rdata_o, exp_res);
      @(negedge clk);
      chk("R8 done single pulse", {31'd0, done_o}, 32'd0);
      chk("R8 idle after done", {31'd0, busy_o}, 32'd0);
   endtask

   initial begin
      bit seen;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 while in reset
      chk("R1 req in reset", {31'd0, mem_req_o}, 32'd0);
      chk("R1 done in reset", {31'd0, done_o}, 32'd0);
      chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
      chk("R1 result in reset", reg_rdata_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {29'd0, mem_req_o, done_o, busy_o}, 32'd0);

      for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

      // R9: start strobe during an ongoing transfer
      run_vec('{32'h0000_6000, 16'h0020, 1'b1, 1'b0, 32'h0102_0304, 2'd2}, 1'b1);

      // R9: start strobe in the very cycle done is high
      @(negedge clk);
      log_n = 0; lat_cfg = 0;
      base_i = 32'h7000; disp_i = 16'h0; size_long_i = 1'b0; dir_rd_i = 1'b1;
      reg_wdata_i = 32'hFFFF_0000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(seen);
      chk("R9 done seen", {31'd0, seen}, 32'd1);
      base_i = 32'h9000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 no restart busy", {31'd0, busy_o}, 32'd0);
      chk("R9 no restart req", {31'd0, mem_req_o}, 32'd0);
      @(negedge clk);
      chk("R9 still idle", {30'd0, busy_o, mem_req_o}, 32'd0);
      chk("R9 access count", log_n, 2);
      chk("R6 upper kept", reg_rdata_o, {16'hFFFF, periph(32'h7000), periph(32'h7002)});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule